// File: doc/BRIEF.md
# Command-Queue SPI Master Sequencer

This block is a single-lane SPI master whose bus activity is scripted by a queue of 32-bit command entries. Each entry does one job. It can select or release a chip select and then wait a number of idle serial-clock periods. It can shift a single opcode byte carried inside the entry. It can also run a counted burst of payload bytes. A burst takes its outgoing bytes from a separate queue of 32-bit transmit words and delivers the received bytes on a byte stream.

Software, or a local controller, loads the entries and the transmit words in advance. The sequencer then plays them back in order. It stops taking new entries when the global enable is low, and a status output shows when the command queue has drained.

Top module: `spi_cmdq_master`

## Requirements
- R1: After reset all chip selects are high (`spi_cs_n` = 2'b11), `spi_sclk` equals `cfg_cpol`, `cmdq_empty` is 1, and `busy` and `rx_valid` are 0.
- R2: Entries run strictly in the order they were pushed, and `cmdq_empty` is 1 only when no entry is waiting.
- R3: An entry with bit16 and bit17 both clear and at least one of bit12 and bit13 set drives chip select low. Bit12 drives `spi_cs_n[0]` and bit13 drives `spi_cs_n[1]`. The sequencer then waits imm×2×HALF_DIV clocks (imm = bits[7:0]) before it takes the next entry.
- R4: An entry with bit16, bit17, bit12 and bit13 all clear releases both chip selects and then holds for imm×2×HALF_DIV clocks.
- R5: An entry with bit16 set and bit8 clear shifts out its own imm byte, MSB first.
- R6: With bit8 set, the byte count is imm when bit9 is clear and 2^imm when bit9 is set. A count of 0 produces no clock edges and uses no transmit word.
- R7: A burst with bit16 set takes its bytes from transmit words, least significant byte first. A word supplies at most 4 bytes, and bytes left in a word at the end of a burst are dropped.
- R8: Any byte shifted by an entry without bit16 is sent as 0xFF.
- R9: Only entries with bit17 set produce received bytes. Each byte gives one single-cycle `rx_valid` pulse, and the byte is assembled MSB first.
- R10: `spi_sclk` rests at `cfg_cpol`. With `cfg_cpha`=0 data is sampled on the leading edge and changed on the trailing edge. With `cfg_cpha`=1 data is changed on the leading edge and sampled on the trailing edge.
- R11: While `cfg_en` is low no new entry is taken and waiting entries stay queued. An entry already taken runs to completion.
- R12: Chip select never changes in the same cycle as a serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Allows new entries to be taken |
| cfg_cpol | input | 1 | Serial clock resting level |
| cfg_cpha | input | 1 | Sampling edge select |
| cmd_valid | input | 1 | Command entry push strobe |
| cmd_data | input | 32 | Command entry |
| cmd_ready | output | 1 | Command queue has room |
| txw_valid | input | 1 | Transmit word push strobe |
| txw_data | input | 32 | Transmit word |
| txw_ready | output | 1 | Transmit word queue has room |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 2 | Chip selects, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| cmdq_empty | output | 1 | Command queue empty |
| busy | output | 1 | An entry is in progress |

## Verification
The hardest case to reach from the ports is a transmit word that is only partly used at the end of a burst, followed by a burst that must begin on a fresh word. It is reached by a six-byte burst, which leaves two padding bytes in its second word. A later burst then has to start from the first byte of the next word, and a zero-length burst placed between them must not consume that word. A behavioural slave in the bench follows each serial-clock edge in all four clock modes, so sampling and launch edges are checked against the bytes it sees and returns. Dropping the enable in the middle of a timed chip-select wait shows that the entry in progress finishes while the following entry stays queued.

// File: rtl/scq_pkg.sv
package scq_pkg;

  typedef struct packed {
    logic [12:0] rsvd;
    logic        stripe;
    logic        rx;
    logic        tx;
    logic        bus_hi;
    logic        bus_lo;
    logic        cs_hi;
    logic        cs_lo;
    logic [1:0]  lanes;
    logic        expo;
    logic        xfer;
    logic [7:0]  imm;
  } scq_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEC   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_BYTE  = 3'd3,
    ST_SHIFT = 3'd4
  } scq_state_e;

endpackage

// File: rtl/scq_fifo.sv
module scq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_wr, do_rd;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (do_wr) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_wr && !do_rd) cnt_n = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end
endmodule

// File: rtl/scq_shifter.sv
module scq_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       active
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          act_q, act_n;
  logic [TW-1:0] tmr_q, tmr_n;
  logic [3:0]    edge_q, edge_n;
  logic          ph_q, ph_n;
  logic [7:0]    sh_q, sh_n;
  logic [7:0]    rx_q, rx_n;
  logic          tick, lead, smp, shf;

  assign tick    = act_q && (tmr_q == '0);
  assign lead    = ~edge_q[0];
  assign smp     = tick && (lead ^ cpha);
  assign shf     = tick && ((!lead && !cpha && edge_q != 4'd15) ||
                            (lead && cpha && edge_q != 4'd0));
  assign done    = tick && (edge_q == 4'd15);
  assign rx_byte = rx_n;
  assign sclk    = cpol ^ ph_q;
  assign mosi    = sh_q[7];
  assign active  = act_q;

  always_comb begin
    act_n  = act_q;
    tmr_n  = tmr_q;
    edge_n = edge_q;
    ph_n   = ph_q;
    sh_n   = sh_q;
    rx_n   = smp ? {rx_q[6:0], miso} : rx_q;
    if (!act_q) begin
      if (start) begin
        act_n  = 1'b1;
        tmr_n  = TW'(HALF - 1);
        edge_n = '0;
        ph_n   = 1'b0;
        sh_n   = tx_byte;
      end
    end else if (tick) begin
      tmr_n  = TW'(HALF - 1);
      ph_n   = ~ph_q;
      edge_n = edge_q + 1'b1;
      if (shf) sh_n = {sh_q[6:0], 1'b1};
      if (edge_q == 4'd15) act_n = 1'b0;
    end else begin
      tmr_n = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      tmr_q  <= '0;
      edge_q <= '0;
      ph_q   <= 1'b0;
      sh_q   <= 8'hFF;
      rx_q   <= '0;
    end else begin
      act_q  <= act_n;
      tmr_q  <= tmr_n;
      edge_q <= edge_n;
      ph_q   <= ph_n;
      sh_q   <= sh_n;
      rx_q   <= rx_n;
    end
  end
endmodule

// File: rtl/scq_seq.sv
module scq_seq
  import scq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HALF  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        cmd_empty,
  input  scq_cmd_t    cmd_word,
  output logic        cmd_pop,
  input  logic        txw_empty,
  input  logic [31:0] txw_word,
  output logic        txw_pop,
  output logic        sh_start,
  output logic [7:0]  sh_byte,
  input  logic        sh_done,
  input  logic [7:0]  sh_rx,
  output logic [1:0]  cs_n,
  output logic        rx_valid,
  output logic [7:0]  rx_data,
  output logic        busy,
  output logic        cur_rx
);
  localparam int PER    = 2 * HALF;
  localparam int WAIT_W = 9 + $clog2(PER);
  localparam int MAXE   = CNT_W - 1;

  scq_state_e        st_q, st_n;
  scq_cmd_t          cmd_q, cmd_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, dec_cnt;
  logic [WAIT_W-1:0] wait_q, wait_n, dec_wait;
  logic [31:0]       word_q, word_n;
  logic              wvld_q, wvld_n;
  logic [1:0]        bidx_q, bidx_n;
  logic [1:0]        cs_q, cs_n_nx;
  logic              rxv_q, rxv_n;
  logic [7:0]        rxd_q, rxd_n;
  logic [7:0]        exp_sel;
  logic              ctrl_only, use_words;

  assign ctrl_only = !cmd_q.tx && !cmd_q.rx;
  assign use_words = cmd_q.tx && cmd_q.xfer;
  assign exp_sel   = (cmd_q.imm > 8'(MAXE)) ? 8'(MAXE) : cmd_q.imm;
  assign dec_wait  = WAIT_W'(cmd_q.imm) * WAIT_W'(PER);

  always_comb begin
    if (!cmd_q.xfer)     dec_cnt = CNT_W'(1);
    else if (cmd_q.expo) dec_cnt = CNT_W'(1) << exp_sel;
    else                 dec_cnt = CNT_W'(cmd_q.imm);
  end

  always_comb begin
    st_n     = st_q;
    cmd_n    = cmd_q;
    cnt_n    = cnt_q;
    wait_n   = wait_q;
    word_n   = word_q;
    wvld_n   = wvld_q;
    bidx_n   = bidx_q;
    cs_n_nx  = cs_q;
    rxv_n    = 1'b0;
    rxd_n    = rxd_q;
    cmd_pop  = 1'b0;
    txw_pop  = 1'b0;
    sh_start = 1'b0;
    sh_byte  = 8'hFF;
    unique case (st_q)
      ST_IDLE: begin
        if (en && !cmd_empty) begin
          cmd_pop = 1'b1;
          cmd_n   = cmd_word;
          st_n    = ST_DEC;
        end
      end
      ST_DEC: begin
        if (ctrl_only) begin
          cs_n_nx = (cmd_q.cs_lo || cmd_q.cs_hi) ? ~{cmd_q.cs_hi, cmd_q.cs_lo} : 2'b11;
          wait_n  = dec_wait;
          st_n    = (cmd_q.imm == 8'd0) ? ST_IDLE : ST_WAIT;
        end else begin
          cnt_n = dec_cnt;
          st_n  = (dec_cnt == '0) ? ST_IDLE : ST_BYTE;
        end
      end
      ST_WAIT: begin
        if (wait_q <= WAIT_W'(1)) st_n = ST_IDLE;
        else wait_n = wait_q - 1'b1;
      end
      ST_BYTE: begin
        if (use_words && !wvld_q) begin
          if (!txw_empty) begin
            txw_pop = 1'b1;
            word_n  = txw_word;
            wvld_n  = 1'b1;
            bidx_n  = 2'd0;
          end
        end else begin
          sh_start = 1'b1;
          if (use_words)     sh_byte = word_q[{bidx_q, 3'b000} +: 8];
          else if (cmd_q.tx) sh_byte = cmd_q.imm;
          else               sh_byte = 8'hFF;
          st_n = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (sh_done) begin
          rxv_n = cmd_q.rx;
          rxd_n = sh_rx;
          cnt_n = cnt_q - 1'b1;
          if (use_words) begin
            bidx_n = bidx_q + 1'b1;
            if (bidx_q == 2'd3 || cnt_q == CNT_W'(1)) begin
              wvld_n = 1'b0;
              bidx_n = 2'd0;
            end
          end
          st_n = (cnt_q == CNT_W'(1)) ? ST_IDLE : ST_BYTE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= '0;
      cnt_q  <= '0;
      wait_q <= '0;
      word_q <= '0;
      wvld_q <= 1'b0;
      bidx_q <= '0;
      cs_q   <= 2'b11;
      rxv_q  <= 1'b0;
      rxd_q  <= '0;
    end else begin
      st_q   <= st_n;
      cmd_q  <= cmd_n;
      cnt_q  <= cnt_n;
      wait_q <= wait_n;
      word_q <= word_n;
      wvld_q <= wvld_n;
      bidx_q <= bidx_n;
      cs_q   <= cs_n_nx;
      rxv_q  <= rxv_n;
      rxd_q  <= rxd_n;
    end
  end

  assign cs_n     = cs_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;
  assign busy     = (st_q != ST_IDLE);
  assign cur_rx   = cmd_q.rx;
endmodule

// File: rtl/spi_cmdq_master.sv
module spi_cmdq_master
  import scq_pkg::*;
#(
  parameter int CMD_DEPTH = 8,
  parameter int TXW_DEPTH = 8,
  parameter int HALF_DIV  = 2,
  parameter int CNT_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_en,
  input  logic        cfg_cpol,
  input  logic        cfg_cpha,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_data,
  output logic        cmd_ready,
  input  logic        txw_valid,
  input  logic [31:0] txw_data,
  output logic        txw_ready,
  output logic        rx_valid,
  output logic [7:0]  rx_data,
  output logic        spi_sclk,
  output logic [1:0]  spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        cmdq_empty,
  output logic        busy
);
  logic        cq_full, cq_empty, cq_pop;
  logic [31:0] cq_word;
  logic        tq_full, tq_empty, tq_pop;
  logic [31:0] tq_word;
  logic        sh_start, sh_done, sh_active;
  logic [7:0]  sh_byte, sh_rx;
  logic        cur_rx;

  scq_fifo #(.W(32), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmd_valid), .wr_data(cmd_data),
    .rd_en(cq_pop), .rd_data(cq_word),
    .full(cq_full), .empty(cq_empty)
  );

  scq_fifo #(.W(32), .DEPTH(TXW_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(txw_valid), .wr_data(txw_data),
    .rd_en(tq_pop), .rd_data(tq_word),
    .full(tq_full), .empty(tq_empty)
  );

  scq_seq #(.CNT_W(CNT_W), .HALF(HALF_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(cfg_en),
    .cmd_empty(cq_empty), .cmd_word(scq_cmd_t'(cq_word)), .cmd_pop(cq_pop),
    .txw_empty(tq_empty), .txw_word(tq_word), .txw_pop(tq_pop),
    .sh_start(sh_start), .sh_byte(sh_byte), .sh_done(sh_done), .sh_rx(sh_rx),
    .cs_n(spi_cs_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .busy(busy), .cur_rx(cur_rx)
  );

  scq_shifter #(.HALF(HALF_DIV)) u_shf (
    .clk(clk), .rst_n(rst_n), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .start(sh_start), .tx_byte(sh_byte), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done),
    .rx_byte(sh_rx), .active(sh_active)
  );

  assign cmd_ready  = !cq_full;
  assign txw_ready  = !tq_full;
  assign cmdq_empty = cq_empty;
endmodule

// File: rtl/scq_checker.sv
module scq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       cfg_cpol,
  input logic       busy,
  input logic       sclk,
  input logic [1:0] cs_n,
  input logic       rx_valid,
  input logic       cur_rx
);
  a_r10_sclk_rests: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_cpol));

  a_r11_no_take_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !busy) |=> !busy);

  a_r9_rx_from_rx_entry: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> cur_rx);

  a_r9_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r12_cs_still_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(sclk) && $stable(cfg_cpol)) |-> $stable(cs_n));
endmodule

bind spi_cmdq_master scq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
  .busy(busy), .sclk(spi_sclk), .cs_n(spi_cs_n),
  .rx_valid(rx_valid), .cur_rx(cur_rx)
);

// File: tb/tb_spi_cmdq_master.sv
module tb_spi_cmdq_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int UNIT = 2 * HALF;

  localparam logic [31:0] B_XFER = 32'h1 << 8;
  localparam logic [31:0] B_EXP  = 32'h1 << 9;
  localparam logic [31:0] M_ONE  = 32'h1 << 10;
  localparam logic [31:0] B_CSL  = 32'h1 << 12;
  localparam logic [31:0] B_CSH  = 32'h1 << 13;
  localparam logic [31:0] B_BUSL = 32'h1 << 14;
  localparam logic [31:0] B_TX   = 32'h1 << 16;
  localparam logic [31:0] B_RX   = 32'h1 << 17;

  logic clk, rst_n, cfg_en, cfg_cpol, cfg_cpha;
  logic cmd_valid, txw_valid, spi_miso;
  logic [31:0] cmd_data, txw_data;
  logic cmd_ready, txw_ready, rx_valid, spi_sclk, spi_mosi, cmdq_empty, busy;
  logic [7:0] rx_data;
  logic [1:0] spi_cs_n;

  int checks = 0, errors = 0, cyc = 0;

  spi_cmdq_master #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .txw_valid(txw_valid), .txw_data(txw_data), .txw_ready(txw_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cmdq_empty(cmdq_empty), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural slave: edge counter, bytes seen and returned
  byte unsigned got_mosi[$], got_miso[$], got_rx[$];
  bit slave_on = 0;
  int s_e = 0, s_bits = 0, s_seed = 0, edges = 0;
  logic [7:0] s_cur, s_acc;

  function automatic logic [7:0] next_byte();
    s_seed++;
    return 8'(8'h3C + 8'(s_seed * 29));
  endfunction

  task automatic slave_prime();
    s_e = 0; s_bits = 0;
    s_cur = next_byte();
    spi_miso = s_cur[7];
    got_mosi.delete(); got_miso.delete(); got_rx.delete();
  endtask

  always @(spi_sclk) begin
    if (slave_on && rst_n && spi_cs_n != 2'b11) begin
      automatic bit lead = (s_e % 2) == 0;
      edges++;
      if (lead ^ cfg_cpha) begin
        s_acc = {s_acc[6:0], spi_mosi};
        s_bits++;
        if (s_bits == 8) begin
          got_mosi.push_back(s_acc);
          got_miso.push_back(s_cur);
          s_bits = 0;
        end
      end
      if (!cfg_cpha && !lead) begin
        if (s_e == 15) begin s_cur = next_byte(); spi_miso = s_cur[7]; end
        else spi_miso = s_cur[6 - s_e / 2];
      end
      if (cfg_cpha && lead) begin
        if (s_e == 0) s_cur = next_byte();
        spi_miso = s_cur[7 - s_e / 2];
      end
      s_e = (s_e + 1) % 16;
    end
  end

  // per-clock model comparison and timing monitors
  logic [1:0] prev_cs;
  logic prev_sclk, edge_pend;
  int t_fall = 0, t_rise = -1000000, gap_edge = -1, gap_hold = -1;
  logic [1:0] cs_low_val;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (rx_valid) got_rx.push_back(rx_data);
      if (spi_cs_n == 2'b11 && !busy)
        check(spi_sclk == cfg_cpol, "R10 sclk rest", spi_sclk, cfg_cpol);
      if (prev_cs == 2'b11 && spi_cs_n != 2'b11) begin
        t_fall = cyc; edge_pend = 1; cs_low_val = spi_cs_n;
        gap_hold = cyc - t_rise;
      end
      if (prev_cs != 2'b11 && spi_cs_n == 2'b11) t_rise = cyc;
      if (edge_pend && spi_sclk != prev_sclk && spi_cs_n != 2'b11) begin
        gap_edge = cyc - t_fall; edge_pend = 0;
      end
    end
    prev_cs = spi_cs_n; prev_sclk = spi_sclk;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic push_cmd(input logic [31:0] w);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_data = w;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    while (!txw_ready) @(negedge clk);
    txw_valid = 1; txw_data = w;
    @(negedge clk);
    txw_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(cmdq_empty && !busy)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha;
    @(negedge clk);
    slave_prime();
  endtask

  initial begin
    int e0;
    rst_n = 0; cfg_en = 1; cfg_cpol = 0; cfg_cpha = 0;
    cmd_valid = 0; txw_valid = 0; cmd_data = '0; txw_data = '0; spi_miso = 1;
    prev_cs = 2'b11; prev_sclk = 0; edge_pend = 0; cs_low_val = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(spi_cs_n == 2'b11, "R1 cs", spi_cs_n, 3);
    check(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
    check(cmdq_empty == 1'b1, "R1 empty", cmdq_empty, 1);
    check(!busy && !rx_valid, "R1 busy/rx", {busy, rx_valid}, 0);
    slave_on = 1;

    // mode 0: select, opcode, 3-byte read, release
    set_mode(0, 0);
    push_cmd(B_BUSL | B_CSL | M_ONE | 32'd5);
    push_cmd(B_BUSL | B_CSL | M_ONE | B_TX | 32'h9F);
    push_cmd(B_BUSL | B_CSL | M_ONE | B_RX | B_XFER | 32'd3);
    push_cmd(B_BUSL | 32'd5);
    check(cmdq_empty == 1'b0, "R2 queued", cmdq_empty, 0);
    wait_idle();
    check(cs_low_val == 2'b10, "R3 lower cs", cs_low_val, 2);
    check(gap_edge >= 5 * UNIT && gap_edge <= 5 * UNIT + 10, "R3 idle gap", gap_edge, 5 * UNIT);
    check(got_mosi.size() == 4, "R2 byte count", got_mosi.size(), 4);
    if (got_mosi.size() == 4) begin
      check(got_mosi[0] == 8'h9F, "R5 opcode", got_mosi[0], 8'h9F);
      for (int i = 1; i < 4; i++) check(got_mosi[i] == 8'hFF, "R8 filler", got_mosi[i], 8'hFF);
    end
    check(got_rx.size() == 3, "R9 rx count", got_rx.size(), 3);
    if (got_rx.size() == 3 && got_miso.size() == 4)
      for (int i = 0; i < 3; i++) check(got_rx[i] == got_miso[i+1], "R9 rx data mode0", got_rx[i], got_miso[i+1]);
    check(spi_cs_n == 2'b11, "R4 release", spi_cs_n, 3);

    // mode 3: 6-byte write from words, release, short opcode frame for hold gap
    set_mode(1, 1);
    push_word(32'h44332211);
    push_word(32'h77776655);
    push_cmd(B_BUSL | B_CSL | M_ONE | 32'd5);
    push_cmd(B_BUSL | B_CSL | M_ONE | B_TX | B_XFER | 32'd6);
    push_cmd(B_BUSL | 32'd5);
    push_cmd(B_BUSL | B_CSL | M_ONE | 32'd1);
    push_cmd(B_BUSL | B_CSL | M_ONE | B_TX | 32'h5A);
    push_cmd(B_BUSL | 32'd0);
    wait_idle();
    check(got_mosi.size() == 7, "R7 count mode3", got_mosi.size(), 7);
    if (got_mosi.size() == 7) begin
      for (int i = 0; i < 6; i++)
        check(got_mosi[i] == 8'(8'h11 * (i + 1)), "R7 lsb first mode3", got_mosi[i], 8'h11 * (i + 1));
      check(got_mosi[6] == 8'h5A, "R10 opcode mode3", got_mosi[6], 8'h5A);
    end
    check(got_rx.size() == 0, "R9 tx only no rx", got_rx.size(), 0);
    check(gap_hold >= 5 * UNIT && gap_hold <= 5 * UNIT + 6, "R4 hold gap", gap_hold, 5 * UNIT);

    // mode 1: exponent burst of 8, write and read
    set_mode(0, 1);
    push_word(32'h0D0C0B0A);
    push_word(32'h11100F0E);
    push_cmd(B_BUSL | B_CSL | M_ONE | 32'd2);
    push_cmd(B_BUSL | B_CSL | M_ONE | B_TX | B_RX | B_XFER | B_EXP | 32'd3);
    push_cmd(B_BUSL | 32'd2);
    wait_idle();
    check(got_mosi.size() == 8, "R6 exp count", got_mosi.size(), 8);
    if (got_mosi.size() == 8)
      for (int i = 0; i < 8; i++) check(got_mosi[i] == 8'(8'h0A + i), "R7 bytes mode1", got_mosi[i], 8'h0A + i);
    check(got_rx.size() == 8, "R9 rx count mode1", got_rx.size(), 8);
    if (got_rx.size() == 8 && got_miso.size() == 8)
      for (int i = 0; i < 8; i++) check(got_rx[i] == got_miso[i], "R10 rx data mode1", got_rx[i], got_miso[i]);

    // mode 2: upper select, zero-length burst, then 2-byte burst on a fresh word
    set_mode(1, 0);
    push_word(32'h7777BBAA);
    push_cmd(B_BUSL | B_CSH | M_ONE | 32'd1);
    e0 = edges;
    push_cmd(B_BUSL | B_CSH | M_ONE | B_TX | B_XFER | 32'd0);
    push_cmd(B_BUSL | B_CSH | M_ONE | B_TX | B_XFER | 32'd2);
    push_cmd(B_BUSL | 32'd1);
    wait_idle();
    check(cs_low_val == 2'b01, "R3 upper cs", cs_low_val, 1);
    check(edges - e0 == 32, "R6 zero count no edges", edges - e0, 32);
    check(got_mosi.size() == 2, "R6 count mode2", got_mosi.size(), 2);
    if (got_mosi.size() == 2) begin
      check(got_mosi[0] == 8'hAA, "R7 fresh word", got_mosi[0], 8'hAA);
      check(got_mosi[1] == 8'hBB, "R7 second byte", got_mosi[1], 8'hBB);
    end

    // enable dropped during a timed select: it completes, next entry stays queued
    set_mode(0, 0);
    push_cmd(B_BUSL | B_CSL | M_ONE | 32'd20);
    push_cmd(B_BUSL | 32'd1);
    @(negedge clk);
    while (!busy) @(negedge clk);
    cfg_en = 0;
    repeat (200) @(negedge clk);
    check(spi_cs_n == 2'b10, "R11 current entry done", spi_cs_n, 2);
    check(cmdq_empty == 1'b0, "R11 next entry kept", cmdq_empty, 0);
    check(!busy, "R11 not busy", busy, 0);
    cfg_en = 1;
    wait_idle();
    check(spi_cs_n == 2'b11, "R11 resumes", spi_cs_n, 3);
    check(cmdq_empty == 1'b1, "R2 drained", cmdq_empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule